// File: doc/BRIEF.md
# Protected Control Register File

This block keeps the configuration and status bytes of a power supervisor and decides, for every write that a serial front end passes in, whether that write may land. The configuration covers a volatile write-enable latch, a hardware-protect enable bit, a two-bit protect code for a 256-byte memory array, a reset delay code and four channel delay codes. The status is a four-bit fault register. The nonvolatile bytes are modelled as ordinary flops.

A write request carries a sector flag (register sector or array), an address and a data byte. One cycle later the block raises exactly one of a grant or a deny strobe. The front end uses the deny strobe to withhold the acknowledge bit. Array writes are not stored here. The block only judges them against the latch and the protect code. A separate read port returns the register image one cycle after the address is presented. A four-bit fail pulse from the sequencer can clear fault bits at any time.

Top module: `prot_regfile`

## Requirements
- R1: After synchronous reset the latch, the protect enable bit, the protect code, the reset delay code, all channel codes, the fault bits, `wr_grant` and `wr_deny` are all 0.
- R2: A cycle with `wr_req` high yields exactly one of `wr_grant` or `wr_deny` high in the following cycle. A cycle without a request yields neither.
- R3: A register write to address 00h with data 80h sets the latch, and data 00h clears it. Such a write is granted whatever the latch, pin or protect state. Any other data value at 00h is denied and leaves the latch unchanged.
- R4: While the latch is 0, writes to register addresses 01h–03h and all array writes are denied, and the configuration stays unchanged.
- R5: A register write to FFh is granted regardless of the latch and the pin. Each data bit 3:0 that is 1 sets the matching fault bit, and a 0 data bit leaves its fault bit as it was.
- R6: A high `fail_pulse[i]` clears fault bit i in the next cycle. This holds even when a write to FFh sets the same bit in the same cycle.
- R7: An array write is denied when its address falls in the protected range selected by the protect code: 00 protects nothing, 01 protects C0h–FFh, 10 protects 80h–FFh, and 11 protects 00h–FFh.
- R8: When `wp_pin` is 1 and the protect enable bit is 1, writes to register addresses 01h–03h are denied. Array writes outside the protected range, and writes to 00h and FFh, are not affected by this condition.
- R9: The register fields sit at these positions: 01h bit 7 is protect enable and bits 4:3 are the protect code. 02h bits 3:2 are the reset delay code. At 03h, channel k (k = 1..4) uses bits 2k-1:2k-2. The output ports show the stored fields.
- R10: `rd_data` shows, one cycle after `rd_addr`, the byte image of the addressed register with its unused bits at 0. 00h shows the latch in bit 7, and FFh shows the fault bits in 3:0. An unmapped register address reads 00h.
- R11: A register-sector write to any address other than 00h, 01h, 02h, 03h or FFh is denied and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request strobe, one cycle per byte |
| wr_sector | input | 1 | 1 = register sector, 0 = memory array |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write data byte |
| wp_pin | input | 1 | Hardware write-protect pin |
| fail_pulse | input | 4 | Per-channel fail pulses from the sequencer |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Registered register image |
| wr_grant | output | 1 | Write accepted (one cycle after request) |
| wr_deny | output | 1 | Write refused; request to withhold acknowledge |
| wel | output | 1 | Write-enable latch |
| wp_en | output | 1 | Hardware-protect enable bit |
| blk_prot | output | 2 | Array protect code |
| rst_dly | output | 2 | Reset delay code |
| chan_dly | output | 8 | Channel delay codes, two bits per channel |
| fault_stat | output | 4 | Fault status bits |

## Verification
A software preset of a fault bit through a write to FFh can land in the same cycle as a hardware fail pulse on that bit. The bench provokes this by writing 0Fh to FFh while pulsing channel 2's fail input. It then expects that one bit to read 0 and the other bits to read 1. The bench also checks that the write itself is still granted. A second case of overlap is the hardware-protect pin together with the latch register. With the pin and the enable bit both high, the bench writes 00h to the latch address and expects the write to be granted even though writes to 01h–03h are refused.

// File: rtl/prf_pkg.sv
`timescale 1ns/1ps
package prf_pkg;
  localparam int AW   = 8;
  localparam int DW   = 8;
  localparam int NCH  = 4;
  localparam int CW   = 2;
  localparam int BPW  = 2;
  localparam int FW   = NCH;
  localparam int CHW  = NCH * CW;

  typedef logic [AW-1:0] addr_t;
  typedef logic [DW-1:0] data_t;

  localparam addr_t A_LATCH = 8'h00;
  localparam addr_t A_PROT  = 8'h01;
  localparam addr_t A_RDLY  = 8'h02;
  localparam addr_t A_CHAN  = 8'h03;
  localparam addr_t A_FAULT = 8'hFF;

  localparam int LATCH_BIT = DW - 1;
  localparam int WPEN_BIT  = DW - 1;
  localparam int BP_LO     = 3;
  localparam int RDLY_LO   = 2;

  localparam data_t LATCH_ON  = data_t'(1) << LATCH_BIT;
  localparam data_t LATCH_OFF = '0;

  typedef struct packed {
    logic latch;
    logic prot;
    logic rdly;
    logic chan;
    logic fault;
  } sel_t;

  // Array protect window: top quarter, top half or everything.
  function automatic logic blk_hit(input logic [BPW-1:0] code, input addr_t a);
    case (code)
      2'b00:   blk_hit = 1'b0;
      2'b01:   blk_hit = &a[AW-1:AW-2];
      2'b10:   blk_hit = a[AW-1];
      default: blk_hit = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/prf_write_gate.sv
`timescale 1ns/1ps
module prf_write_gate
  import prf_pkg::*;
(
  input  logic           sector,
  input  addr_t          addr,
  input  data_t          data,
  input  logic           wel,
  input  logic           wpen,
  input  logic           wp_pin,
  input  logic [BPW-1:0] bp,
  output logic           allow,
  output sel_t           sel
);
  logic hw_lock;
  assign hw_lock = wp_pin & wpen;

  always_comb begin
    sel   = '0;
    allow = 1'b0;
    if (!sector) begin
      allow = wel & ~blk_hit(bp, addr);
    end else begin
      case (addr)
        A_LATCH: begin
          sel.latch = 1'b1;
          allow     = (data == LATCH_ON) || (data == LATCH_OFF);
        end
        A_PROT: begin
          sel.prot = 1'b1;
          allow    = wel & ~hw_lock;
        end
        A_RDLY: begin
          sel.rdly = 1'b1;
          allow    = wel & ~hw_lock;
        end
        A_CHAN: begin
          sel.chan = 1'b1;
          allow    = wel & ~hw_lock;
        end
        A_FAULT: begin
          sel.fault = 1'b1;
          allow     = 1'b1;
        end
        default: allow = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/prf_fault_reg.sv
`timescale 1ns/1ps
module prf_fault_reg
  import prf_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] set_mask,
  input  logic [FW-1:0] clr_mask,
  output logic [FW-1:0] q
);
  for (genvar i = 0; i < FW; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)              q[i] <= 1'b0;
      else if (clr_mask[i]) q[i] <= 1'b0;
      else if (set_mask[i]) q[i] <= 1'b1;
    end

    // R6
    hw_clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
      clr_mask[i] |=> !q[i]);
  end
endmodule

// File: rtl/prf_read_mux.sv
`timescale 1ns/1ps
module prf_read_mux
  import prf_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  addr_t          rd_addr,
  input  logic           wel,
  input  logic           wpen,
  input  logic [BPW-1:0] bp,
  input  logic [CW-1:0]  rdly,
  input  logic [CHW-1:0] chan,
  input  logic [FW-1:0]  fault,
  output data_t          rd_data
);
  data_t img;
  logic  mapped;

  always_comb begin
    img    = '0;
    mapped = 1'b1;
    case (rd_addr)
      A_LATCH: img[LATCH_BIT] = wel;
      A_PROT: begin
        img[WPEN_BIT]       = wpen;
        img[BP_LO +: BPW]   = bp;
      end
      A_RDLY:  img[RDLY_LO +: CW] = rdly;
      A_CHAN:  img[CHW-1:0] = chan;
      A_FAULT: img[FW-1:0] = fault;
      default: mapped = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= img;
  end

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> (rd_data == '0));
endmodule

// File: rtl/prot_regfile.sv
`timescale 1ns/1ps
module prot_regfile
  import prf_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_req,
  input  logic           wr_sector,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           wp_pin,
  input  logic [FW-1:0]  fail_pulse,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           wr_grant,
  output logic           wr_deny,
  output logic           wel,
  output logic           wp_en,
  output logic [BPW-1:0] blk_prot,
  output logic [CW-1:0]  rst_dly,
  output logic [CHW-1:0] chan_dly,
  output logic [FW-1:0]  fault_stat
);
  logic          allow;
  sel_t          sel;
  logic          fire;
  logic [FW-1:0] fault_set;

  prf_write_gate u_gate (
    .sector (wr_sector),
    .addr   (wr_addr),
    .data   (wr_data),
    .wel    (wel),
    .wpen   (wp_en),
    .wp_pin (wp_pin),
    .bp     (blk_prot),
    .allow  (allow),
    .sel    (sel)
  );

  assign fire      = wr_req & allow;
  assign fault_set = (fire && sel.fault) ? wr_data[FW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_grant <= 1'b0;
      wr_deny  <= 1'b0;
      wel      <= 1'b0;
      wp_en    <= 1'b0;
      blk_prot <= '0;
      rst_dly  <= '0;
      chan_dly <= '0;
    end else begin
      wr_grant <= wr_req & allow;
      wr_deny  <= wr_req & ~allow;
      if (fire) begin
        if (sel.latch) wel <= wr_data[LATCH_BIT];
        if (sel.prot) begin
          wp_en    <= wr_data[WPEN_BIT];
          blk_prot <= wr_data[BP_LO +: BPW];
        end
        if (sel.rdly) rst_dly  <= wr_data[RDLY_LO +: CW];
        if (sel.chan) chan_dly <= wr_data[CHW-1:0];
      end
    end
  end

  prf_fault_reg u_fault (
    .clk      (clk),
    .rst      (rst),
    .set_mask (fault_set),
    .clr_mask (fail_pulse),
    .q        (fault_stat)
  );

  prf_read_mux u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (rd_addr),
    .wel     (wel),
    .wpen    (wp_en),
    .bp      (blk_prot),
    .rdly    (rst_dly),
    .chan    (chan_dly),
    .fault   (fault_stat),
    .rd_data (rd_data)
  );

  logic cfg_hit;
  assign cfg_hit = wr_sector && (wr_addr == A_PROT || wr_addr == A_RDLY || wr_addr == A_CHAN);

  // R2
  grant_deny_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_grant && wr_deny));

  // R2
  resp_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_req |=> !(wr_grant || wr_deny));

  // R3
  latch_bad_value_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && wr_sector && wr_addr == A_LATCH && wr_data != LATCH_ON && wr_data != LATCH_OFF)
    |=> (wr_deny && $stable(wel)));

  // R4
  latch_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wel && (cfg_hit || !wr_sector)) |=> wr_deny);

  // R7
  array_all_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_sector && blk_prot == 2'b11) |=> wr_deny);

  // R8
  hw_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && cfg_hit && wp_pin && wp_en) |=> (wr_deny && $stable(blk_prot) && $stable(wp_en)));
endmodule

// File: tb/prot_regfile_test.sv
`timescale 1ns/1ps
module prot_regfile_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_req, wr_sector, wp_pin;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [3:0] fail_pulse;
  logic       wr_grant, wr_deny, wel, wp_en;
  logic [1:0] blk_prot, rst_dly;
  logic [7:0] chan_dly;
  logic [3:0] fault_stat;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  prot_regfile uut (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_sector(wr_sector),
    .wr_addr(wr_addr), .wr_data(wr_data), .wp_pin(wp_pin),
    .fail_pulse(fail_pulse), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_grant(wr_grant), .wr_deny(wr_deny), .wel(wel), .wp_en(wp_en),
    .blk_prot(blk_prot), .rst_dly(rst_dly), .chan_dly(chan_dly),
    .fault_stat(fault_stat)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // {req, sector, addr, data, wp, fail, grant, deny,
  //  wel, wpen, bp, rdly, chan, fault, req_tag}
  localparam int NV = 26;
  localparam logic [46:0] VEC [NV] = '{
    {1'b1,1'b1,8'h01,8'h98,1'b0,4'h0,1'b0,1'b1, 1'b0,1'b0,2'd0,2'd0,8'h00,4'h0, 4'd4},  // R4
    {1'b1,1'b1,8'h00,8'h80,1'b0,4'h0,1'b1,1'b0, 1'b1,1'b0,2'd0,2'd0,8'h00,4'h0, 4'd3},  // R3
    {1'b1,1'b1,8'h00,8'h81,1'b0,4'h0,1'b0,1'b1, 1'b1,1'b0,2'd0,2'd0,8'h00,4'h0, 4'd3},  // R3
    {1'b1,1'b1,8'h02,8'h0C,1'b0,4'h0,1'b1,1'b0, 1'b1,1'b0,2'd0,2'd3,8'h00,4'h0, 4'd9},  // R9
    {1'b1,1'b1,8'h03,8'hE4,1'b0,4'h0,1'b1,1'b0, 1'b1,1'b0,2'd0,2'd3,8'hE4,4'h0, 4'd9},  // R9
    {1'b1,1'b1,8'h01,8'h08,1'b0,4'h0,1'b1,1'b0, 1'b1,1'b0,2'd1,2'd3,8'hE4,4'h0, 4'd9},  // R9
    {1'b1,1'b0,8'hC0,8'h55,1'b0,4'h0,1'b0,1'b1, 1'b1,1'b0,2'd1,2'd3,8'hE4,4'h0, 4'd7},  // R7
    {1'b1,1'b0,8'hBF,8'h55,1'b0,4'h0,1'b1,1'b0, 1'b1,1'b0,2'd1,2'd3,8'hE4,4'h0, 4'd7},  // R7
    {1'b1,1'b1,8'h01,8'h10,1'b0,4'h0,1'b1,1'b0, 1'b1,1'b0,2'd2,2'd3,8'hE4,4'h0, 4'd9},  // R9
    {1'b1,1'b0,8'h80,8'h55,1'b0,4'h0,1'b0,1'b1, 1'b1,1'b0,2'd2,2'd3,8'hE4,4'h0, 4'd7},  // R7
    {1'b1,1'b0,8'h7F,8'h55,1'b0,4'h0,1'b1,1'b0, 1'b1,1'b0,2'd2,2'd3,8'hE4,4'h0, 4'd7},  // R7
    {1'b1,1'b1,8'h01,8'h98,1'b0,4'h0,1'b1,1'b0, 1'b1,1'b1,2'd3,2'd3,8'hE4,4'h0, 4'd9},  // R9
    {1'b1,1'b0,8'h00,8'h55,1'b0,4'h0,1'b0,1'b1, 1'b1,1'b1,2'd3,2'd3,8'hE4,4'h0, 4'd7},  // R7
    {1'b1,1'b1,8'h01,8'h00,1'b1,4'h0,1'b0,1'b1, 1'b1,1'b1,2'd3,2'd3,8'hE4,4'h0, 4'd8},  // R8
    {1'b1,1'b1,8'h02,8'h00,1'b1,4'h0,1'b0,1'b1, 1'b1,1'b1,2'd3,2'd3,8'hE4,4'h0, 4'd8},  // R8
    {1'b1,1'b1,8'h01,8'h80,1'b0,4'h0,1'b1,1'b0, 1'b1,1'b1,2'd0,2'd3,8'hE4,4'h0, 4'd8},  // R8
    {1'b1,1'b0,8'h00,8'h55,1'b1,4'h0,1'b1,1'b0, 1'b1,1'b1,2'd0,2'd3,8'hE4,4'h0, 4'd8},  // R8
    {1'b1,1'b1,8'hFF,8'h05,1'b1,4'h0,1'b1,1'b0, 1'b1,1'b1,2'd0,2'd3,8'hE4,4'h5, 4'd5},  // R5
    {1'b1,1'b1,8'h10,8'h00,1'b0,4'h0,1'b0,1'b1, 1'b1,1'b1,2'd0,2'd3,8'hE4,4'h5, 4'd11}, // R11
    {1'b1,1'b1,8'h00,8'h00,1'b1,4'h0,1'b1,1'b0, 1'b0,1'b1,2'd0,2'd3,8'hE4,4'h5, 4'd3},  // R3
    {1'b1,1'b1,8'hFF,8'h0A,1'b0,4'h0,1'b1,1'b0, 1'b0,1'b1,2'd0,2'd3,8'hE4,4'hF, 4'd5},  // R5
    {1'b1,1'b1,8'h03,8'h00,1'b0,4'h0,1'b0,1'b1, 1'b0,1'b1,2'd0,2'd3,8'hE4,4'hF, 4'd4},  // R4
    {1'b1,1'b0,8'h00,8'h55,1'b0,4'h0,1'b0,1'b1, 1'b0,1'b1,2'd0,2'd3,8'hE4,4'hF, 4'd4},  // R4
    {1'b0,1'b0,8'h00,8'h00,1'b0,4'h1,1'b0,1'b0, 1'b0,1'b1,2'd0,2'd3,8'hE4,4'hE, 4'd6},  // R6
    {1'b1,1'b1,8'hFF,8'h0F,1'b0,4'h2,1'b1,1'b0, 1'b0,1'b1,2'd0,2'd3,8'hE4,4'hD, 4'd6},  // R6
    {1'b0,1'b0,8'h00,8'h00,1'b0,4'h0,1'b0,1'b0, 1'b0,1'b1,2'd0,2'd3,8'hE4,4'hD, 4'd2}   // R2
  };

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp);
    rd_addr = a;
    @(negedge clk);
    chk($sformatf("R10 read %h", a), {24'h0, rd_data}, {24'h0, exp});
  endtask

  task automatic reset_chk(input string tag);
    chk({tag, " grant/deny"}, {30'h0, wr_grant, wr_deny}, 32'h0);
    chk({tag, " state"}, {14'h0, wel, wp_en, blk_prot, rst_dly, chan_dly, fault_stat}, 32'h0);
  endtask

  initial begin
    rst = 1'b1; wr_req = 0; wr_sector = 0; wr_addr = 0; wr_data = 0;
    wp_pin = 0; fail_pulse = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    reset_chk("R1");

    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      v = VEC[i];
      {wr_req, wr_sector, wr_addr, wr_data, wp_pin, fail_pulse} = v[46:24];
      @(negedge clk);
      chk($sformatf("R%0d vec %0d resp", v[3:0], i), {30'h0, wr_grant, wr_deny}, {30'h0, v[23:22]});
      chk($sformatf("R%0d vec %0d state", v[3:0], i),
          {14'h0, wel, wp_en, blk_prot, rst_dly, chan_dly, fault_stat}, {14'h0, v[21:4]});
    end
    {wr_req, wr_sector, wr_addr, wr_data, wp_pin, fail_pulse} = '0;

    // R10 register images from the final state; R9 field positions in bytes
    rd_chk(8'h00, 8'h00);
    rd_chk(8'h01, 8'h80);
    rd_chk(8'h02, 8'h0C);
    rd_chk(8'h03, 8'hE4);
    rd_chk(8'hFF, 8'h0D);
    rd_chk(8'h40, 8'h00);

    // R1 reset in mid-run clears everything again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    reset_chk("R1 rerun");
    rd_chk(8'h03, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule